// File: doc/BRIEF.md
# Early/Late Depth Test Scheduler

This block sits between fragment generation and the fragment shader and decides, for each draw, whether depth testing and depth writes happen before shading, partly before and partly after, or entirely after shading. The decision comes from the draw's shader properties and its depth compare function. The inputs are whether the shader may discard, whether it writes depth, and in which direction it promises to move depth. Keeping the test early means hidden fragments never reach the shader. Moving the write or the whole test late keeps the depth result correct when the shader can drop a fragment or change its depth.

Each incoming fragment carries a pixel address and an interpolated depth. It is checked against a small on-block depth store indexed by pixel. The block issues a request on the shader port only when the fragment must be shaded. Shader responses return in request order with a keep flag and a final depth. For modes that defer the write, the block performs the final test and the depth update when the response arrives. Fragments to one pixel keep their arrival order: a fragment is held back while an earlier fragment to the same pixel still has a deferred write outstanding.

Top module: `dz_sched`

## Requirements
- R1: The mode output `mode_o` follows the draw configuration. It is 0 (all early) when the shader neither discards nor writes depth. It is 1 (early test, deferred write) when the shader discards but does not write depth. It is also 1 when the shader writes depth and the declared direction is safe. In every other depth-writing case it is 2 (fully late). Direction code 1 means final depth is never below the interpolated depth and is safe for LESS or LEQUAL. Direction code 2 means final depth is never above it and is safe for GREATER or GEQUAL. Code 0 declares nothing.
- R2: Compare codes are LESS=0, LEQUAL=1, GREATER=2, GEQUAL=3, EQUAL=4 and ALWAYS=5. A fragment passes when its depth relates to the stored depth as the code names; ALWAYS always passes.
- R3: In modes 0 and 1, a fragment failing the early test is retired in its accept cycle with `res_valid`=1, `res_written`=0 and `res_shaded`=0, and no shader request is raised.
- R4: In mode 0, a passing fragment writes its depth at the accept edge and raises a shader request in the same cycle. It reports `res_written`=1 and `res_shaded`=1 in that cycle, and its later shader response produces no result.
- R5: In mode 1, a passing fragment raises a shader request without writing depth. At the response the final depth is retested against the store and written on pass, and the result is reported in the response cycle. The final depth is the returned depth if the shader writes depth, else the interpolated one.
- R6: In mode 2, every accepted fragment raises a shader request and no early result. The test and any write happen only at the response.
- R7: A response with keep=0 never updates the depth store and reports `res_written`=0.
- R8: A fragment whose pixel has an outstanding deferred-write entry is not accepted (`frag_ready`=0) until that entry's response has been retired.
- R9: After reset every stored depth is all ones, `res_valid` and `shd_req_valid` are low, and `frag_ready` is high.
- R10: `frag_ready` is low while a shader response is presented, while NPEND requests are outstanding, or while `shd_req_ready` is low.
- R11: Responses are matched to requests in issue order, so `res_addr` of deferred results follows the order of the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cmp | input | 3 | Depth compare code (R2) |
| cfg_discard | input | 1 | Shader may discard |
| cfg_wr_depth | input | 1 | Shader writes depth |
| cfg_cons | input | 2 | Declared depth direction (R1) |
| mode_o | output | 2 | Selected scheduling mode |
| frag_valid | input | 1 | Fragment present |
| frag_ready | output | 1 | Fragment accepted this cycle when valid |
| frag_addr | input | AW | Pixel index |
| frag_z | input | ZW | Interpolated depth |
| shd_req_valid | output | 1 | Shader request for the accepted fragment |
| shd_req_ready | input | 1 | Shader can take a request |
| shd_req_addr | output | AW | Pixel of the request |
| shd_rsp_valid | input | 1 | Shader response for the oldest request |
| shd_rsp_keep | input | 1 | Fragment survives shading |
| shd_rsp_z | input | ZW | Final depth from the shader |
| res_valid | output | 1 | A fragment is retired with a depth result |
| res_addr | output | AW | Pixel of the result |
| res_written | output | 1 | Depth store was updated |
| res_shaded | output | 1 | Fragment went through the shader |

## Verification
On every cycle the embedded properties check several things. No response is taken without a pending request and no request is pushed into a full queue. A presented response blocks fragment acceptance, and a mode-2 accept always requests shading. A keep=0 response never reports a write, and a mode-0 pass leaves the fragment's depth in the store on the next cycle. Only the bench's scenarios can show the rest: the compare codes across stored values, the mode choice for each configuration, retesting of a returned depth, hold-off of a same-pixel fragment and response ordering. For these it compares every port each cycle against a behavioural model of the depth store and the pending queue.

// File: rtl/dz_pkg.sv
package dz_pkg;
  typedef enum logic [2:0] {
    ZF_LESS    = 3'd0,
    ZF_LEQUAL  = 3'd1,
    ZF_GREATER = 3'd2,
    ZF_GEQUAL  = 3'd3,
    ZF_EQUAL   = 3'd4,
    ZF_ALWAYS  = 3'd5
  } zfunc_e;

  typedef enum logic [1:0] {
    CD_NONE = 2'd0,
    CD_UP   = 2'd1,
    CD_DOWN = 2'd2
  } cdir_e;

  typedef enum logic [1:0] {
    ZM_EARLY        = 2'd0,
    ZM_EARLY_LATEWR = 2'd1,
    ZM_LATE         = 2'd2
  } zmode_e;
endpackage

// File: rtl/dz_mode_sel.sv
module dz_mode_sel
  import dz_pkg::*;
(
  input  logic [2:0] cmp,
  input  logic       discard,
  input  logic       wr_depth,
  input  logic [1:0] cons,
  output zmode_e     mode
);
  logic up_safe;
  logic down_safe;

  always_comb begin
    up_safe   = (cons == CD_UP)   && ((cmp == ZF_LESS)    || (cmp == ZF_LEQUAL));
    down_safe = (cons == CD_DOWN) && ((cmp == ZF_GREATER) || (cmp == ZF_GEQUAL));
    if (wr_depth) begin
      mode = (up_safe || down_safe) ? ZM_EARLY_LATEWR : ZM_LATE;
    end else if (discard) begin
      mode = ZM_EARLY_LATEWR;
    end else begin
      mode = ZM_EARLY;
    end
  end
endmodule

// File: rtl/dz_cmp.sv
module dz_cmp
  import dz_pkg::*;
#(
  parameter int ZW = 16
) (
  input  logic [2:0]    func,
  input  logic [ZW-1:0] z_new,
  input  logic [ZW-1:0] z_ref,
  output logic          pass
);
  always_comb begin
    case (func)
      ZF_LESS:    pass = z_new <  z_ref;
      ZF_LEQUAL:  pass = z_new <= z_ref;
      ZF_GREATER: pass = z_new >  z_ref;
      ZF_GEQUAL:  pass = z_new >= z_ref;
      ZF_EQUAL:   pass = z_new == z_ref;
      default:    pass = 1'b1;
    endcase
  end
endmodule

// File: rtl/dz_pend_fifo.sv
module dz_pend_fifo
  import dz_pkg::*;
#(
  parameter int AW    = 4,
  parameter int ZW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [ZW-1:0] push_z,
  input  zmode_e        push_mode,
  input  logic          push_wd,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [ZW-1:0] head_z,
  output zmode_e        head_mode,
  output logic          head_wd,
  input  logic [AW-1:0] look_addr,
  output logic          hazard,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [ZW-1:0]    z_q    [DEPTH];
  zmode_e           mode_q [DEPTH];
  logic [DEPTH-1:0] wd_q;
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [PW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [DEPTH-1:0] hit;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    vld_d = vld_q;
    if (push) begin
      wp_d        = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      vld_d[wp_q] = 1'b1;
    end
    if (pop) begin
      rp_d        = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      vld_d[rp_q] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      vld_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wp_q] <= push_addr;
      z_q[wp_q]    <= push_z;
      mode_q[wp_q] <= push_mode;
      wd_q[wp_q]   <= push_wd;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_look
      assign hit[i] = vld_q[i] && (mode_q[i] != ZM_EARLY) && (addr_q[i] == look_addr);
    end
  endgenerate

  assign hazard    = |hit;
  assign full      = &vld_q;
  assign empty     = ~|vld_q;
  assign head_addr = addr_q[rp_q];
  assign head_z    = z_q[rp_q];
  assign head_mode = mode_q[rp_q];
  assign head_wd   = wd_q[rp_q];

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/dz_sched.sv
module dz_sched
  import dz_pkg::*;
#(
  parameter int            ZW      = 16,
  parameter int            AW      = 4,
  parameter int            NPEND   = 4,
  parameter logic [ZW-1:0] CLEAR_Z = {ZW{1'b1}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cfg_cmp,
  input  logic          cfg_discard,
  input  logic          cfg_wr_depth,
  input  logic [1:0]    cfg_cons,
  output logic [1:0]    mode_o,
  input  logic          frag_valid,
  output logic          frag_ready,
  input  logic [AW-1:0] frag_addr,
  input  logic [ZW-1:0] frag_z,
  output logic          shd_req_valid,
  input  logic          shd_req_ready,
  output logic [AW-1:0] shd_req_addr,
  input  logic          shd_rsp_valid,
  input  logic          shd_rsp_keep,
  input  logic [ZW-1:0] shd_rsp_z,
  output logic          res_valid,
  output logic [AW-1:0] res_addr,
  output logic          res_written,
  output logic          res_shaded
);
  localparam int NPIX = 1 << AW;

  zmode_e        mode;
  logic [ZW-1:0] zmem_q [NPIX];
  logic [ZW-1:0] zmem_d [NPIX];
  logic          hazard, full, empty;
  logic [AW-1:0] h_addr;
  logic [ZW-1:0] h_z;
  zmode_e        h_mode;
  logic          h_wd;
  logic          acc, e_pass, e_we, e_res, req;
  logic          h_late, l_pass, l_we;
  logic [ZW-1:0] l_z;

  dz_mode_sel u_mode (
    .cmp      (cfg_cmp),
    .discard  (cfg_discard),
    .wr_depth (cfg_wr_depth),
    .cons     (cfg_cons),
    .mode     (mode)
  );

  dz_cmp #(.ZW(ZW)) u_cmp_early (
    .func  (cfg_cmp),
    .z_new (frag_z),
    .z_ref (zmem_q[frag_addr]),
    .pass  (e_pass)
  );

  dz_cmp #(.ZW(ZW)) u_cmp_late (
    .func  (cfg_cmp),
    .z_new (l_z),
    .z_ref (zmem_q[h_addr]),
    .pass  (l_pass)
  );

  dz_pend_fifo #(.AW(AW), .ZW(ZW), .DEPTH(NPEND)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (req),
    .push_addr (frag_addr),
    .push_z    (frag_z),
    .push_mode (mode),
    .push_wd   (cfg_wr_depth),
    .pop       (shd_rsp_valid),
    .head_addr (h_addr),
    .head_z    (h_z),
    .head_mode (h_mode),
    .head_wd   (h_wd),
    .look_addr (frag_addr),
    .hazard    (hazard),
    .full      (full),
    .empty     (empty)
  );

  // acceptance and early stage
  always_comb begin
    frag_ready = !full && !hazard && !shd_rsp_valid && shd_req_ready;
    acc        = frag_valid && frag_ready;
    e_we       = 1'b0;
    e_res      = 1'b0;
    req        = 1'b0;
    case (mode)
      ZM_EARLY: begin
        req   = acc && e_pass;
        e_we  = acc && e_pass;
        e_res = acc;
      end
      ZM_EARLY_LATEWR: begin
        req   = acc && e_pass;
        e_res = acc && !e_pass;
      end
      default: begin
        req   = acc;
      end
    endcase
  end

  // late stage at the shader response
  always_comb begin
    h_late = shd_rsp_valid && (h_mode != ZM_EARLY);
    l_z    = h_wd ? shd_rsp_z : h_z;
    l_we   = h_late && shd_rsp_keep && l_pass;
  end

  always_comb begin
    zmem_d = zmem_q;
    if (e_we) zmem_d[frag_addr] = frag_z;
    if (l_we) zmem_d[h_addr]    = l_z;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPIX; i++) zmem_q[i] <= CLEAR_Z;
    end else begin
      zmem_q <= zmem_d;
    end
  end

  assign mode_o        = mode;
  assign shd_req_valid = req;
  assign shd_req_addr  = frag_addr;
  assign res_valid     = e_res || h_late;
  assign res_addr      = shd_rsp_valid ? h_addr : frag_addr;
  assign res_written   = shd_rsp_valid ? l_we : e_we;
  assign res_shaded    = shd_rsp_valid || req;

  // R10
  rsp_blocks_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shd_rsp_valid |-> !frag_ready);
  // R6
  late_always_shades_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == ZM_LATE && frag_valid && frag_ready) |-> shd_req_valid);
  // R7
  drop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shd_rsp_valid && !shd_rsp_keep) |-> !res_written);
  // R4
  early_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == ZM_EARLY && res_valid && res_written && !shd_rsp_valid)
      |=> (zmem_q[$past(res_addr)] == $past(frag_z)));
  // R3
  early_fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_written && !shd_rsp_valid && mode_o != ZM_LATE) |-> !shd_req_valid);
endmodule

// File: tb/test_dz_sched.sv
module test_dz_sched;
  localparam int ZW = 16;
  localparam int AW = 4;
  localparam int NPEND = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    cfg_cmp;
  logic          cfg_discard, cfg_wr_depth;
  logic [1:0]    cfg_cons, mode_o;
  logic          frag_valid, frag_ready;
  logic [AW-1:0] frag_addr;
  logic [ZW-1:0] frag_z;
  logic          shd_req_valid, shd_req_ready;
  logic [AW-1:0] shd_req_addr;
  logic          shd_rsp_valid, shd_rsp_keep;
  logic [ZW-1:0] shd_rsp_z;
  logic          res_valid, res_written, res_shaded;
  logic [AW-1:0] res_addr;

  always #4 clk = ~clk;

  dz_sched #(.ZW(ZW), .AW(AW), .NPEND(NPEND)) i_dz_sched (
    .clk(clk), .rst_n(rst_n), .cfg_cmp(cfg_cmp), .cfg_discard(cfg_discard),
    .cfg_wr_depth(cfg_wr_depth), .cfg_cons(cfg_cons), .mode_o(mode_o),
    .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_addr(frag_addr),
    .frag_z(frag_z), .shd_req_valid(shd_req_valid), .shd_req_ready(shd_req_ready),
    .shd_req_addr(shd_req_addr), .shd_rsp_valid(shd_rsp_valid),
    .shd_rsp_keep(shd_rsp_keep), .shd_rsp_z(shd_rsp_z), .res_valid(res_valid),
    .res_addr(res_addr), .res_written(res_written), .res_shaded(res_shaded)
  );

  typedef struct {
    int addr;
    int z;
    int md;
    bit wd;
  } pend_t;

  pend_t pq[$];
  int    zm[16];
  int    n_run = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    live = 1'b0;
  string tag = "R9";

  task automatic chk(string rq, string what, longint act, longint exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("[TB] FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic bit zt(int f, int a, int b);
    case (f)
      0: return a < b;
      1: return a <= b;
      2: return a > b;
      3: return a >= b;
      4: return a == b;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int mdl_mode();
    bit safe;
    safe = (cfg_cons == 2'd1 && (cfg_cmp == 3'd0 || cfg_cmp == 3'd1)) ||
           (cfg_cons == 2'd2 && (cfg_cmp == 3'd2 || cfg_cmp == 3'd3));
    if (cfg_wr_depth) return safe ? 1 : 2;
    if (cfg_discard) return 1;
    return 0;
  endfunction

  // reference model, compared on every cycle
  always @(negedge clk) begin
    int md, ra, fd;
    bit hz, rdy, acc, ep, req, rv, rw, rs;
    pend_t h;
    if (live) begin
      md = mdl_mode();
      hz = 1'b0;
      foreach (pq[i]) if (pq[i].md != 0 && pq[i].addr == int'(frag_addr)) hz = 1'b1;
      rdy = (pq.size() < NPEND) && !hz && !shd_rsp_valid && shd_req_ready;
      acc = frag_valid && rdy;
      ep  = zt(int'(cfg_cmp), int'(frag_z), zm[frag_addr]);
      req = 1'b0; rv = 1'b0; rw = 1'b0; rs = 1'b0; ra = 0;
      if (acc) begin
        req = (md == 2) ? 1'b1 : ep;
        if (md == 0) begin
          rv = 1'b1; rw = ep; rs = ep; ra = int'(frag_addr);
        end else if (md == 1 && !ep) begin
          rv = 1'b1; ra = int'(frag_addr);
        end
      end
      if (shd_rsp_valid) begin
        if (pq.size() == 0) begin
          chk(tag, "response with nothing pending", 1, 0);
        end else begin
          h = pq.pop_front();
          if (h.md != 0) begin
            fd = h.wd ? int'(shd_rsp_z) : h.z;
            rv = 1'b1; rs = 1'b1; ra = h.addr;
            rw = shd_rsp_keep && zt(int'(cfg_cmp), fd, zm[h.addr]);
            if (rw) zm[h.addr] = fd;
          end
        end
      end
      chk(tag, "mode_o", mode_o, md);
      chk(tag, "frag_ready", frag_ready, rdy);
      chk(tag, "shd_req_valid", shd_req_valid, req);
      if (req) chk(tag, "shd_req_addr", shd_req_addr, frag_addr);
      chk(tag, "res_valid", res_valid, rv);
      if (rv) begin
        chk(tag, "res_addr", res_addr, ra);
        chk(tag, "res_written", res_written, rw);
        chk(tag, "res_shaded", res_shaded, rs);
      end
      if (acc && md == 0 && ep) zm[frag_addr] = int'(frag_z);
      if (req) pq.push_back('{int'(frag_addr), int'(frag_z), md, cfg_wr_depth});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("[TB] FAIL R11 watchdog: actual %0d expected below %0d cycles", cyc, 20000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic send(int a, int z);
    bit got;
    frag_valid = 1'b1;
    frag_addr  = AW'(a);
    frag_z     = ZW'(z);
    do begin
      @(negedge clk);
      got = frag_ready;
      step();
    end while (!got);
    frag_valid = 1'b0;
  endtask

  task automatic resp(bit k, int z);
    shd_rsp_valid = 1'b1;
    shd_rsp_keep  = k;
    shd_rsp_z     = ZW'(z);
    step();
    shd_rsp_valid = 1'b0;
  endtask

  task automatic drain();
    while (pq.size() != 0) resp(1'b1, 0);
  endtask

  task automatic sd(int a, int z);
    send(a, z);
    drain();
  endtask

  task automatic setcfg(int f, bit d, bit w, int c);
    cfg_cmp      = 3'(f);
    cfg_discard  = d;
    cfg_wr_depth = w;
    cfg_cons     = 2'(c);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) zm[i] = 16'hFFFF;
    rst_n = 1'b0;
    setcfg(0, 0, 0, 0);
    frag_valid = 1'b0; frag_addr = '0; frag_z = '0;
    shd_req_ready = 1'b1;
    shd_rsp_valid = 1'b0; shd_rsp_keep = 1'b0; shd_rsp_z = '0;
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    // R9: idle outputs after reset
    chk("R9", "res_valid after reset", res_valid, 0);
    chk("R9", "shd_req_valid after reset", shd_req_valid, 0);
    chk("R9", "frag_ready after reset", frag_ready, 1);
    chk("R1", "mode after reset", mode_o, 0);
    step();
    live = 1'b1;

    // R9: stored depth starts at all ones (equal fails LESS, one below passes)
    tag = "R9";
    sd(15, 16'hFFFF);
    sd(15, 16'hFFFE);
    // R3 / R4: early mode passes and fails
    tag = "R4";
    sd(15, 100);
    tag = "R3";
    sd(15, 200);
    sd(15, 100);

    // R2: every compare code against a preloaded value
    tag = "R2";
    for (int f = 0; f < 6; f++) begin
      setcfg(5, 0, 0, 0);
      sd(f, 16'h4000);
      setcfg(f, 0, 0, 0);
      sd(f, 16'h4000);
      sd(f, 16'h3000);
      sd(f, 16'h5000);
      sd(f, 16'h4000);
    end

    // R5 / R8 / R7: discard mode, same-pixel hold-off, dropped fragment
    setcfg(0, 1, 0, 0);
    tag = "R5";
    send(5, 50);
    tag = "R8";
    frag_valid = 1'b1; frag_addr = 4'd5; frag_z = 16'd40;
    step();
    step();
    tag = "R7";
    shd_rsp_valid = 1'b1; shd_rsp_keep = 1'b0; shd_rsp_z = 16'd0;
    step();
    shd_rsp_valid = 1'b0;
    tag = "R8";
    step();
    frag_valid = 1'b0;
    tag = "R5";
    resp(1'b1, 0);
    sd(5, 45);

    // R6: shader writes depth with no declaration
    setcfg(0, 0, 1, 0);
    tag = "R6";
    send(7, 16'hFFFF);
    resp(1'b1, 30);
    send(7, 10);
    resp(1'b1, 60);

    // R5 / R1: safe upward declaration keeps the early test
    setcfg(0, 0, 1, 1);
    tag = "R5";
    sd(7, 40);
    send(7, 20);
    resp(1'b1, 25);
    send(7, 20);
    resp(1'b1, 26);

    // R1: other declaration combinations
    tag = "R1";
    setcfg(0, 0, 1, 2);
    step();
    setcfg(5, 0, 1, 1);
    step();
    setcfg(2, 0, 1, 2);
    sd(13, 16'h0100);
    sd(13, 16'hFFFF);
    setcfg(2, 1, 0, 0);
    step();

    // R11: deferred results follow request order
    setcfg(0, 0, 1, 0);
    tag = "R11";
    send(2, 0);
    send(6, 0);
    send(14, 0);
    resp(1'b1, 100);
    resp(1'b1, 200);
    resp(1'b0, 50);

    // R10: queue full, then shader not ready
    setcfg(0, 0, 0, 0);
    tag = "R10";
    send(8, 10);
    send(9, 10);
    send(10, 10);
    send(11, 10);
    frag_valid = 1'b1; frag_addr = 4'd12; frag_z = 16'd10;
    step();
    step();
    frag_valid = 1'b0;
    drain();
    shd_req_ready = 1'b0;
    frag_valid = 1'b1;
    step();
    step();
    shd_req_ready = 1'b1;
    step();
    frag_valid = 1'b0;
    drain();
    step();

    live = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule